// File: doc/BRIEF.md
# Dual-Bank Program/Erase Arbiter

This block decides, request by request, whether a flash device split into two equal banks may accept a read or a modify (program or erase). Bank A or bank B is picked by the most significant bit of the word address. While one bank runs a program or an erase, reads of the other bank are granted with normal data. Reads aimed at the busy bank are also granted, but they are marked so the read path returns a status word instead of array data. Only one bank may ever be in a modify state. Any modify request made while an operation runs is refused.

An erase can be suspended. While it is suspended, its bank reads normally, and one program may be started in that bank. A resume given while that program runs is held until the program finishes. The timing engine is outside this block. It reports the end of each operation with a one-cycle `op_done` pulse.

A hardware reset pin held low for `RST_MIN_CYC` consecutive clocks aborts all activity. After it is released, requests are refused for a recovery window. A shorter low pulse aborts nothing, but requests are still refused while the pin is low. The open-drain ready/busy indication is modelled as `rb_drive_low`.

Top module: `dual_bank_arbiter`

## Requirements
- R1: Each request sampled with `req_valid`=1 is answered exactly one clock later with exactly one of `req_grant` or `req_reject`. When no request was sampled, both are 0.
- R2: The bank of a request is `req_addr[ADDR_W-1]` (0 = bank A, 1 = bank B). An unlocked read (`req_write`=0) is always granted. `req_status` is 1 exactly when the addressed bank's `bank_busy` bit was 1 at that request.
- R3: A modify request (`req_write`=1; `req_erase`=1 selects erase, 0 selects program) made with nothing running and nothing suspended is granted. On the next clock, `bank_busy` has only the addressed bank's bit set, where bit 0 is bank A and bit 1 is bank B, and `rb_drive_low`=1.
- R4: While `rb_drive_low`=1, every modify request to either bank is rejected. `bank_busy` never has both bits set.
- R5: `op_done` ends the running operation: the busy bit and `rb_drive_low` clear on the next clock. `op_done` with nothing running changes nothing.
- R6: `susp_cmd` during a running erase puts its bank back in read mode: the busy bit and `rb_drive_low` clear. While the erase is suspended, erase requests are rejected. `susp_cmd` during a program, or with nothing running, is ignored.
- R7: While an erase is suspended, one program to the suspended bank is granted and sets its busy bit. A program to the other bank, or a second program, is rejected.
- R8: `resume_cmd` on a suspended erase with no program running restarts the erase: its busy bit is set on the next clock. If a suspend-time program is running, the resume is held, and the erase restarts on the `op_done` of that program, so the busy bit stays set. `resume_cmd` with no suspended erase is ignored.
- R9: `hw_rst_n` low for `RST_MIN_CYC` consecutive clocks clears all operations, suspends and held resumes. A shorter low pulse leaves them unchanged.
- R10: Requests are rejected in every cycle `hw_rst_n` is low. After an abort, they are also rejected for the first `RECOVERY_CYC`+1 clocks with `hw_rst_n` high. A short pulse starts no recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst_n | input | 1 | Hardware reset pin, active low, sampled |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = modify, 0 = read |
| req_erase | input | 1 | For a modify: 1 = erase, 0 = program |
| req_addr | input | ADDR_W | Word address; MSB selects the bank |
| op_done | input | 1 | One-cycle end-of-operation pulse from the engine |
| susp_cmd | input | 1 | Erase suspend command |
| resume_cmd | input | 1 | Erase resume command |
| req_grant | output | 1 | Request accepted (one cycle after strobe) |
| req_reject | output | 1 | Request refused (one cycle after strobe) |
| req_status | output | 1 | Granted read hit a busy bank; return status |
| bank_busy | output | 2 | Per-bank busy mode, bit 0 = A, bit 1 = B |
| rb_drive_low | output | 1 | Pull the ready/busy line low (busy) |

## Verification
The bench builds the block with `ADDR_W`=4, `RST_MIN_CYC`=3 and `RECOVERY_CYC`=4. A 16-word address space lets every address be swept, for both reads and modifies, in each busy configuration (idle, bank A busy, bank B busy, each with program and erase). The short reset values make it cheap to try every pulse length from 1 to 3 cycles. They also let the bench walk the recovery window clock by clock, including the first cycle in which a request is granted again.

// File: rtl/dual_bank_arbiter.sv
module dual_bank_arbiter #(
  parameter int ADDR_W       = 21,
  parameter int RST_MIN_CYC  = 8,
  parameter int RECOVERY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              op_done,
  input  logic              susp_cmd,
  input  logic              resume_cmd,
  output logic              req_grant,
  output logic              req_reject,
  output logic              req_status,
  output logic [1:0]        bank_busy,
  output logic              rb_drive_low
);
  localparam int LW = $clog2(RST_MIN_CYC + 1);
  localparam int RW = $clog2(RECOVERY_CYC + 1);

  logic run, run_erase, bank, susp, sprog, rpend, armed;
  logic [LW-1:0] lo_cnt;
  logic [RW-1:0] rec_cnt;
  logic n_run, n_erase, n_bank, n_susp, n_sprog, n_rpend;
  logic gnt, rej, sts;

  wire sel    = req_addr[ADDR_W-1];
  wire active = run | sprog;
  wire locked = !hw_rst_n || armed || (rec_cnt != '0);
  wire abort  = !hw_rst_n && (lo_cnt == LW'(RST_MIN_CYC - 1));

  assign bank_busy    = active ? (bank ? 2'b10 : 2'b01) : 2'b00;
  assign rb_drive_low = active;

  always_comb begin
    n_run = run; n_erase = run_erase; n_bank = bank;
    n_susp = susp; n_sprog = sprog; n_rpend = rpend;
    gnt = 1'b0; rej = 1'b0; sts = 1'b0;
    if (op_done) begin
      if (sprog) begin
        n_sprog = 1'b0;
        if (rpend) begin
          n_rpend = 1'b0; n_susp = 1'b0; n_run = 1'b1; n_erase = 1'b1;
        end
      end else if (run) n_run = 1'b0;
    end
    if (susp_cmd && n_run && n_erase) begin
      n_run = 1'b0; n_susp = 1'b1;
    end
    if (resume_cmd && n_susp) begin
      if (n_sprog) n_rpend = 1'b1;
      else begin n_susp = 1'b0; n_run = 1'b1; n_erase = 1'b1; end
    end
    if (req_valid) begin
      if (locked) rej = 1'b1;
      else if (!req_write) begin
        gnt = 1'b1; sts = bank_busy[sel];
      end else if (!run && !susp && !sprog) begin
        gnt = 1'b1; n_run = 1'b1; n_erase = req_erase; n_bank = sel;
      end else if (susp && !sprog && !req_erase && sel == bank) begin
        gnt = 1'b1; n_sprog = 1'b1;
      end else rej = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; run_erase <= 1'b0; bank <= 1'b0; susp <= 1'b0;
      sprog <= 1'b0; rpend <= 1'b0; armed <= 1'b0;
      lo_cnt <= '0; rec_cnt <= '0;
      req_grant <= 1'b0; req_reject <= 1'b0; req_status <= 1'b0;
    end else begin
      req_grant  <= gnt;
      req_reject <= rej;
      req_status <= sts;
      if (hw_rst_n) lo_cnt <= '0;
      else if (lo_cnt != LW'(RST_MIN_CYC)) lo_cnt <= lo_cnt + 1'b1;
      if (abort) begin
        run <= 1'b0; run_erase <= 1'b0; susp <= 1'b0;
        sprog <= 1'b0; rpend <= 1'b0; armed <= 1'b1;
      end else begin
        run <= n_run; run_erase <= n_erase; bank <= n_bank;
        susp <= n_susp; sprog <= n_sprog; rpend <= n_rpend;
      end
      if (hw_rst_n && armed) begin
        armed   <= 1'b0;
        rec_cnt <= RW'(RECOVERY_CYC);
      end else if (rec_cnt != '0) rec_cnt <= rec_cnt - 1'b1;
    end
  end

  assert_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (req_grant ^ req_reject));
  assert_single_modify_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&bank_busy));
  assert_busy_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && rb_drive_low) |=> req_reject);
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !rb_drive_low);
  assert_pin_low_locks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hw_rst_n) |=> req_reject);
endmodule

// File: tb/dual_bank_arbiter_bench.sv
module dual_bank_arbiter_bench;
  localparam int AW = 4, RMIN = 3, RREC = 4;
  logic clk = 0, rst_n = 0, hw_rst_n = 1;
  logic req_valid = 0, req_write = 0, req_erase = 0;
  logic [AW-1:0] req_addr = '0;
  logic op_done = 0, susp_cmd = 0, resume_cmd = 0;
  logic req_grant, req_reject, req_status, rb_drive_low;
  logic [1:0] bank_busy;
  int checks = 0, errors = 0;
  bit finished = 0;

  dual_bank_arbiter #(.ADDR_W(AW), .RST_MIN_CYC(RMIN), .RECOVERY_CYC(RREC)) u_dual_bank_arbiter (
    .clk, .rst_n, .hw_rst_n, .req_valid, .req_write, .req_erase, .req_addr,
    .op_done, .susp_cmd, .resume_cmd, .req_grant, .req_reject, .req_status,
    .bank_busy, .rb_drive_low);

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rq(bit w, bit e, int a, int exp_g, int exp_s, string req);
    req_valid = 1; req_write = w; req_erase = e; req_addr = AW'(a);
    tick();
    req_valid = 0; req_write = 0; req_erase = 0;
    chk(req, req_grant, exp_g);
    chk(req, req_reject, 1 - exp_g);
    if (exp_g == 1 && !w) chk(req, req_status, exp_s);
  endtask

  task automatic pulse_done(); op_done = 1; tick(); op_done = 0; endtask
  task automatic pulse_susp(); susp_cmd = 1; tick(); susp_cmd = 0; endtask
  task automatic pulse_res(); resume_cmd = 1; tick(); resume_cmd = 0; endtask

  task automatic busy_is(string req, int exp);
    chk(req, bank_busy, exp);
    chk(req, rb_drive_low, exp != 0 ? 1 : 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 reset grant", req_grant, 0);
    chk("R1 reset reject", req_reject, 0);
    busy_is("R3 reset idle", 0);
    rst_n = 1;
    tick();
    for (int a = 0; a < 16; a++) rq(0, 0, a, 1, 0, "R2 idle read");
    tick();
    chk("R1 no request", req_grant + req_reject, 0);

    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 2; k++) begin
        rq(1, k[0], b * 8 + 3, 1, 0, "R3 start modify");
        busy_is("R3 busy bank", 1 << b);
        for (int a = 0; a < 16; a++) rq(0, 0, a, 1, ((a >> 3) == b) ? 1 : 0, "R2 read status");
        for (int a = 0; a < 16; a++) begin
          rq(1, 0, a, 0, 0, "R4 program refused");
          rq(1, 1, a, 0, 0, "R4 erase refused");
        end
        busy_is("R4 still one bank", 1 << b);
        pulse_done();
        busy_is("R5 done clears", 0);
      end
    pulse_done();
    busy_is("R5 idle done ignored", 0);
    rq(1, 0, 9, 1, 0, "R5 idle after stray done");
    busy_is("R3 program bank B", 2);
    pulse_susp();
    busy_is("R6 suspend of program ignored", 2);
    pulse_done();
    pulse_susp();
    busy_is("R6 idle suspend ignored", 0);

    rq(1, 1, 1, 1, 0, "R3 erase bank A");
    pulse_susp();
    busy_is("R6 suspended erase readable", 0);
    rq(0, 0, 5, 1, 0, "R6 read suspended bank");
    rq(1, 1, 5, 0, 0, "R6 erase during suspend");
    rq(1, 1, 12, 0, 0, "R6 erase other bank during suspend");
    rq(1, 0, 9, 0, 0, "R7 program other bank");
    rq(1, 0, 2, 1, 0, "R7 program suspended bank");
    busy_is("R7 busy again", 1);
    rq(1, 0, 3, 0, 0, "R7 second program");
    pulse_res();
    busy_is("R8 resume held", 1);
    pulse_done();
    busy_is("R8 erase resumed after program", 1);
    rq(0, 0, 4, 1, 1, "R8 resumed bank status");
    pulse_done();
    busy_is("R5 erase done", 0);
    pulse_res();
    busy_is("R8 idle resume ignored", 0);
    rq(1, 1, 14, 1, 0, "R3 erase bank B");
    pulse_susp();
    busy_is("R6 suspend bank B", 0);
    pulse_res();
    busy_is("R8 direct resume", 2);

    for (int len = 1; len < RMIN; len++) begin
      hw_rst_n = 0;
      rq(0, 0, 0, 0, 0, "R10 pin low rejects");
      for (int i = 1; i < len; i++) tick();
      hw_rst_n = 1;
      rq(0, 0, 0, 1, 0, "R10 short pulse no recovery");
      busy_is("R9 short pulse keeps", 2);
    end
    hw_rst_n = 0;
    for (int i = 0; i < RMIN; i++) tick();
    busy_is("R9 abort clears", 0);
    hw_rst_n = 1;
    for (int k = 0; k <= RREC + 1; k++) rq(0, 0, 8, (k > RREC) ? 1 : 0, 0, "R10 recovery window");
    pulse_res();
    busy_is("R9 suspend state cleared", 0);
    rq(1, 0, 6, 1, 0, "R9 modify after recovery");
    busy_is("R3 program after recovery", 1);
    pulse_done();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule